// File: doc/BRIEF.md
# Dual-Law SPI Bit-Clock Divider

This block turns a fast module clock into the timing reference for an SPI shift engine. It does not make a new clock. It produces a one-cycle toggle strobe at twice the serial clock rate, and a registered serial-clock phase level that flips on every strobe. The shift engine uses the strobe to move data and the phase to drive its clock pin.

The divisor comes from a 13-bit control word that holds two divisor fields with different division laws. A select bit picks which field is used. The linear field gives a serial clock of the module clock divided by 2×(N+1). The exponent field gives a serial clock of the module clock divided by 2^(N+1). The divider runs only while its enable is held high, which is normally for the length of one transfer. A new control word takes effect only at a toggle boundary, so the phase keeps its 50% duty cycle and has no short half-periods.

Top module: `sclk_dual_div`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tgl_stb` and `sclk_ph` are both 0.
- R2: When `div_cfg[12]` is 1 (linear law), the 8-bit field `div_cfg[7:0]` = N makes `tgl_stb` pulse once every N+1 module cycles. The serial clock is then the module clock divided by 2×(N+1).
- R3: When the linear law is selected with N = 0, `tgl_stb` is high in every enabled cycle and `sclk_ph` toggles every cycle (module clock divided by 2).
- R4: When `div_cfg[12]` is 0 (power-of-two law), the 4-bit field `div_cfg[11:8]` = N makes `tgl_stb` pulse once every 2^N module cycles. The serial clock is then the module clock divided by 2^(N+1).
- R5: If `div_en` is first seen high at a clock edge and the period in force is L cycles, the first `tgl_stb` pulse follows the L-th enabled edge.
- R6: `sclk_ph` starts at 0 when enabled and changes value exactly on the cycles where `tgl_stb` is high. As a result, the high and low halves of the phase are equal.
- R7: A change to `div_cfg` while `div_en` is high does not alter the interval in progress. The new value sets the period from the next strobe onward.
- R8: While `div_en` is low, `tgl_stb` stays 0, `sclk_ph` stays 0, and the cycle count restarts from zero.
- R9: A value written to `div_cfg` while `div_en` is low takes effect at once. The first interval after enabling already uses it.
- R10: The field of the law that is not selected has no effect on the strobe period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | Run enable, held high while a transfer is active |
| div_cfg | input | 13 | Control word: [12] law select, [11:8] exponent, [7:0] linear count |
| tgl_stb | output | 1 | One-cycle pulse at twice the serial clock rate |
| sclk_ph | output | 1 | Registered serial-clock phase |

## Verification
The bound checker checks several properties on every cycle. It checks that the outputs go quiet and low one cycle after the enable drops, and that the phase changes only together with a strobe. It checks that every strobe flips the phase. It also checks that the gap between strobes never exceeds the largest possible period. Only the bench's scenarios can show the exact interval lengths for each law and field value, including the fastest linear setting. The same holds for the deferred effect of a change made while running, for the immediate effect of a change made while idle, and for the unselected field being ignored.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    localparam int LIN_W  = 8;
    localparam int EXP_W  = 4;
    localparam int CFG_W  = LIN_W + EXP_W + 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int TERM_W = (LIN_W > EXP_MAX) ? LIN_W : EXP_MAX;

    typedef logic [TERM_W-1:0] term_t;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } div_law_e;

    // Bit layout: [12] law, [11:8] exponent, [7:0] linear count.
    typedef struct packed {
        div_law_e           law;
        logic [EXP_W-1:0]   exp_n;
        logic [LIN_W-1:0]   lin_n;
    } div_cfg_t;

    // Last count value of one toggle interval (interval length minus one).
    function automatic term_t cfg_to_term(div_cfg_t c);
        term_t t;
        if (c.law == LAW_LINEAR) begin
            t = term_t'(c.lin_n);
        end else begin
            t = term_t'((32'd1 << c.exp_n) - 32'd1);
        end
        return t;
    endfunction

endpackage

// File: rtl/sclk_law_dec.sv
module sclk_law_dec
    import sclk_div_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_raw,
    output term_t            term
);
    div_cfg_t cfg_s;

    always_comb begin
        cfg_s = div_cfg_t'(cfg_raw);
        term  = cfg_to_term(cfg_s);
    end
endmodule

// File: rtl/sclk_tick_cnt.sv
module sclk_tick_cnt
    import sclk_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  term_t term_in,
    output logic  hit
);
    term_t cnt_q;
    term_t term_q;

    assign hit = run && (cnt_q == term_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            term_q <= term_in;
        end else if (hit) begin
            cnt_q  <= '0;
            term_q <= term_in;
        end else begin
            cnt_q  <= cnt_q + term_t'(1);
        end
    end
endmodule

// File: rtl/sclk_phase_reg.sv
module sclk_phase_reg (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    output logic stb,
    output logic ph
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            stb <= 1'b0;
            ph  <= 1'b0;
        end else begin
            stb <= hit;
            if (hit) begin
                ph <= ~ph;
            end
        end
    end
endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
    import sclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_en,
    input  logic [CFG_W-1:0] div_cfg,
    output logic             tgl_stb,
    output logic             sclk_ph
);
    term_t term_w;
    logic  hit_w;

    sclk_law_dec u_dec (
        .cfg_raw (div_cfg),
        .term    (term_w)
    );

    sclk_tick_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (div_en),
        .term_in (term_w),
        .hit     (hit_w)
    );

    sclk_phase_reg u_ph (
        .clk (clk),
        .rst (rst),
        .run (div_en),
        .hit (hit_w),
        .stb (tgl_stb),
        .ph  (sclk_ph)
    );
endmodule

// File: rtl/sclk_dual_div_chk.sv
module sclk_dual_div_chk
    import sclk_div_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic div_en,
    input logic tgl_stb,
    input logic sclk_ph
);
    localparam int GAP_W = TERM_W + 2;
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(1) << TERM_W;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !div_en || tgl_stb) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !div_en |=> (!tgl_stb && !sclk_ph)); // R8

    AST_STB_FLIPS_PH: assert property (@(posedge clk) disable iff (rst)
        tgl_stb |-> (sclk_ph != $past(sclk_ph))); // R6

    AST_PH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(div_en) && !tgl_stb) |-> $stable(sclk_ph)); // R6

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_q <= GAP_MAX); // R4

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!tgl_stb && !sclk_ph)); // R1
endmodule

bind sclk_dual_div sclk_dual_div_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .div_en  (div_en),
    .tgl_stb (tgl_stb),
    .sclk_ph (sclk_ph)
);

// File: tb/sclk_dual_div_tb.sv
module sclk_dual_div_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_en = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        tgl_stb;
    logic        sclk_ph;

    int n_chk = 0;
    int n_bad = 0;
    bit exp_ph = 1'b0;

    always #2 clk = ~clk;

    sclk_dual_div u_dut (
        .clk     (clk),
        .rst     (rst),
        .div_en  (div_en),
        .div_cfg (div_cfg),
        .tgl_stb (tgl_stb),
        .sclk_ph (sclk_ph)
    );

    function automatic logic [12:0] mk_lin(int n, int junk);
        return {1'b1, 4'(junk), 8'(n)};
    endfunction

    function automatic logic [12:0] mk_pow(int n, int junk);
        return {1'b0, 4'(n), 8'(junk)};
    endfunction

    function automatic int exp_len(logic [12:0] c);
        if (c[12]) return int'(c[7:0]) + 1;
        return 1 << c[11:8];
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Counts negedges until a strobe is seen; called right after the last strobe
    // or right after enabling.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tgl_stb && n < 70000);
    endtask

    task automatic run_intervals(string req, int expv, int cnt);
        int got;
        for (int i = 0; i < cnt; i++) begin
            measure(got);
            check(got == expv, req, got, expv);
            exp_ph = ~exp_ph;
            check(sclk_ph == exp_ph, "R6", int'(sclk_ph), int'(exp_ph));
        end
    endtask

    task automatic start(logic [12:0] c);
        @(negedge clk);
        div_en  = 1'b0;
        div_cfg = c;
        @(negedge clk);
        exp_ph  = 1'b0;
        div_en  = 1'b1;
    endtask

    initial begin
        int seed;
        int got;
        int n;
        int jk;
        logic [12:0] c;
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        check(!tgl_stb && !sclk_ph, "R1", int'({tgl_stb, sclk_ph}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!tgl_stb && !sclk_ph, "R1", int'({tgl_stb, sclk_ph}), 0);

        // R3: fastest linear rate
        start(mk_lin(0, 9));
        run_intervals("R3", 1, 4);

        // R5: first strobe after exactly L enabled edges (linear and pow2)
        start(mk_lin(6, 0));
        run_intervals("R5", 7, 1);
        start(mk_pow(3, 0));
        run_intervals("R5", 8, 1);

        // R2 boundary: largest linear count
        start(mk_lin(255, 3));
        run_intervals("R2", 256, 2);

        // R7: change while running applies after next strobe
        start(mk_lin(4, 0));
        run_intervals("R7", 5, 1);
        div_cfg = mk_lin(1, 0);
        run_intervals("R7", 5, 1);
        run_intervals("R7", 2, 2);

        // R8: disable silences outputs
        @(negedge clk);
        div_en = 1'b0;
        got = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tgl_stb || sclk_ph) got++;
        end
        check(got == 0, "R8", got, 0);

        // R9: change while idle applies immediately
        div_cfg = mk_pow(2, 0);
        @(negedge clk);
        exp_ph = 1'b0;
        div_en = 1'b1;
        run_intervals("R9", 4, 2);

        // R10: unselected field ignored in both laws
        start(mk_lin(2, 15));
        run_intervals("R10", 3, 2);
        start(mk_pow(1, 200));
        run_intervals("R10", 2, 2);

        // R2 / R4 random mix
        for (int k = 0; k < 24; k++) begin
            jk = int'($urandom_range(0, 255));
            if ($urandom_range(0, 1) == 1) begin
                n = int'($urandom_range(0, 255));
                c = mk_lin(n, jk);
                start(c);
                run_intervals("R2", exp_len(c), 3);
            end else begin
                n = int'($urandom_range(0, 8));
                c = mk_pow(n, jk);
                start(c);
                run_intervals("R4", exp_len(c), 3);
            end
        end

        @(negedge clk);
        div_en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule